// File: doc/BRIEF.md
# Fractional Multiply Unit with Signed/Unsigned Mode

This block holds a multiplier register, a product-high register and a one-bit unsigned-mode flag. Each accepted command carries a 5-bit operation code and a 16-bit operand. Loading the multiplier register also picks the arithmetic mode: one code selects two's-complement mode and another selects unsigned mode. A multiply forms the full 32-bit product of the multiplier register and the operand in the current mode, and only the upper half is kept in the product-high register. An optional rounding step adds half of one upper-half unit before the upper half is taken. The product-high register can also be loaded straight from the operand.

Commands arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, so every cycle with `in_valid` high is a transfer. All results appear on the rising edge that follows the transfer. A zero flag and a sign flag report the 16-bit value of the most recent register load. Multiplies leave both flags unchanged.

Top module: `fmu_top`

## Requirements
- R1: After reset, the multiplier register, the product-high register, the unsigned-mode flag, the zero flag and the sign flag all read 0.
- R2: A transfer with code 5'b11000 loads the operand into the multiplier register and clears the unsigned-mode flag on the next rising edge.
- R3: A transfer with code 5'b11001 loads the operand into the multiplier register and sets the unsigned-mode flag on the next rising edge.
- R4: A transfer with code 5'b11011 while the mode flag is 0 writes bits 31:16 of the two's-complement product of the multiplier register and the operand into the product-high register.
- R5: A transfer with code 5'b11011 while the mode flag is 1 writes bits 31:16 of the unsigned product into the product-high register.
- R6: A transfer with code 5'b11010 adds 32'h0000_8000 to the 32-bit product, in the current mode and modulo 2^32 without saturation, and writes bits 31:16 of the sum into the product-high register.
- R7: Both multiply codes leave the zero flag, the sign flag, the multiplier register and the mode flag unchanged.
- R8: A transfer with code 5'b10001 loads the operand into the product-high register and leaves the multiplier register and the mode flag unchanged.
- R9: On each of the three load codes, the zero flag becomes 1 exactly when the loaded 16-bit value is 0, and the sign flag becomes bit 15 of that value.
- R10: A cycle with `in_valid` low, or a transfer with any other code, changes no register or flag.
- R11: `in_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command accepted (always 1) |
| in_opcode | input | 5 | Operation code |
| in_operand | input | 16 | Memory operand |
| mr_q | output | 16 | Multiplier register |
| ph_q | output | 16 | Product-high register |
| um_q | output | 1 | Unsigned-mode flag (1 = unsigned) |
| zero_flag | output | 1 | Transfer status: loaded value was zero |
| sign_flag | output | 1 | Transfer status: bit 15 of loaded value |

## Verification
The hardest case to reach is a rounding multiply whose 32-bit sum wraps past 2^32. In signed mode this needs a small negative product, at or above 32'hFFFF_8000, so the rounded upper half rolls over to zero. Random operands almost never land in that window. Directed commands therefore set the multiplier register to small values of opposite sign, such as 1 times -1 and -1 times 0x7FFF. They also cover the extreme products -32768 squared and 0xFFFF squared in unsigned mode. A fixed-seed random stream then mixes all codes, idle cycles and undefined codes, with alternating mode loads.

// File: rtl/fmu_pkg.sv
package fmu_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_LD_MR_S = 5'b11000;
  localparam logic [OPC_W-1:0] OPC_LD_MR_U = 5'b11001;
  localparam logic [OPC_W-1:0] OPC_MUL_RND = 5'b11010;
  localparam logic [OPC_W-1:0] OPC_MUL     = 5'b11011;
  localparam logic [OPC_W-1:0] OPC_LD_PH   = 5'b10001;

  typedef struct packed {
    logic ld_mr;
    logic ld_ph;
    logic mul;
    logic rnd;
    logic um_val;
  } fmu_ctrl_t;
endpackage

// File: rtl/fmu_decode.sv
module fmu_decode
  import fmu_pkg::*;
(
  input  logic             valid,
  input  logic [OPC_W-1:0] opcode,
  output fmu_ctrl_t        ctrl
);
  always_comb begin
    ctrl = '0;
    if (valid) begin
      unique case (opcode)
        OPC_LD_MR_S: begin ctrl.ld_mr = 1'b1; ctrl.um_val = 1'b0; end
        OPC_LD_MR_U: begin ctrl.ld_mr = 1'b1; ctrl.um_val = 1'b1; end
        OPC_MUL:     ctrl.mul = 1'b1;
        OPC_MUL_RND: begin ctrl.mul = 1'b1; ctrl.rnd = 1'b1; end
        OPC_LD_PH:   ctrl.ld_ph = 1'b1;
        default:     ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/fmu_multiplier.sv
module fmu_multiplier #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              unsigned_mode,
  input  logic              round_en,
  output logic [DATA_W-1:0] upper
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W  = DATA_W + 1;
  localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (DATA_W - 1);

  logic signed [EXT_W-1:0]   a_ext, b_ext;
  logic signed [2*EXT_W-1:0] full;
  logic [PROD_W-1:0]         prod, sum;

  // One signed multiplier serves both modes: the extra top bit is
  // either a copy of the sign bit or a forced zero.
  always_comb begin
    a_ext = $signed({(~unsigned_mode) & a[DATA_W-1], a});
    b_ext = $signed({(~unsigned_mode) & b[DATA_W-1], b});
    full  = a_ext * b_ext;
    prod  = full[PROD_W-1:0];
    sum   = prod + (round_en ? HALF_LSB : '0);
    upper = sum[PROD_W-1:DATA_W];
  end
endmodule

// File: rtl/fmu_status.sv
module fmu_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update,
  input  logic [DATA_W-1:0] value,
  output logic              zero_flag,
  output logic              sign_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_flag <= 1'b0;
      sign_flag <= 1'b0;
    end else if (update) begin
      zero_flag <= (value == '0);
      sign_flag <= value[DATA_W-1];
    end
  end
endmodule

// File: rtl/fmu_top.sv
module fmu_top
  import fmu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [DATA_W-1:0] in_operand,
  output logic [DATA_W-1:0] mr_q,
  output logic [DATA_W-1:0] ph_q,
  output logic              um_q,
  output logic              zero_flag,
  output logic              sign_flag
);
  fmu_ctrl_t         ctrl;
  logic [DATA_W-1:0] mul_upper;

  assign in_ready = 1'b1;

  fmu_decode u_decode (
    .valid  (in_valid & in_ready),
    .opcode (in_opcode),
    .ctrl   (ctrl)
  );

  fmu_multiplier #(.DATA_W(DATA_W)) u_mult (
    .a             (mr_q),
    .b             (in_operand),
    .unsigned_mode (um_q),
    .round_en      (ctrl.rnd),
    .upper         (mul_upper)
  );

  fmu_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .update    (ctrl.ld_mr | ctrl.ld_ph),
    .value     (in_operand),
    .zero_flag (zero_flag),
    .sign_flag (sign_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q <= '0;
      um_q <= 1'b0;
    end else if (ctrl.ld_mr) begin
      mr_q <= in_operand;
      um_q <= ctrl.um_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ph_q <= '0;
    else if (ctrl.ld_ph) ph_q <= in_operand;
    else if (ctrl.mul)   ph_q <= mul_upper;
  end
endmodule

// File: rtl/fmu_checker.sv
module fmu_checker
  import fmu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OPC_W-1:0]  in_opcode,
  input logic [DATA_W-1:0] in_operand,
  input logic [DATA_W-1:0] mr_q,
  input logic [DATA_W-1:0] ph_q,
  input logic              um_q,
  input logic              zero_flag,
  input logic              sign_flag
);
  logic is_mul;
  assign is_mul = in_valid && (in_opcode == OPC_MUL || in_opcode == OPC_MUL_RND);

  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R2
  mr_signed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_opcode == OPC_LD_MR_S |=> mr_q == $past(in_operand) && !um_q);

  // R3
  mr_unsigned_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_opcode == OPC_LD_MR_U |=> mr_q == $past(in_operand) && um_q);

  // R7
  mul_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mul |=> $stable(zero_flag) && $stable(sign_flag) && $stable(mr_q) && $stable(um_q));

  // R8
  ph_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_opcode == OPC_LD_PH |=> ph_q == $past(in_operand) && $stable(mr_q));

  // R9
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_opcode == OPC_LD_PH || in_opcode == OPC_LD_MR_S || in_opcode == OPC_LD_MR_U)
    |=> zero_flag == ($past(in_operand) == '0) && sign_flag == $past(in_operand[DATA_W-1]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mr_q) && $stable(ph_q) && $stable(um_q)
                  && $stable(zero_flag) && $stable(sign_flag));
endmodule

bind fmu_top fmu_checker #(.DATA_W(DATA_W)) u_fmu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_opcode  (in_opcode),
  .in_operand (in_operand),
  .mr_q       (mr_q),
  .ph_q       (ph_q),
  .um_q       (um_q),
  .zero_flag  (zero_flag),
  .sign_flag  (sign_flag)
);

// File: tb/test_fmu_top.sv
module test_fmu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_opcode = '0;
  logic [15:0] in_operand = '0;
  logic [15:0] mr_q, ph_q;
  logic        um_q, zero_flag, sign_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] e_mr = '0, e_ph = '0;
  logic        e_um = 0, e_z = 0, e_s = 0;

  always #10 clk = ~clk;

  fmu_top i_fmu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_operand(in_operand), .mr_q(mr_q), .ph_q(ph_q),
    .um_q(um_q), .zero_flag(zero_flag), .sign_flag(sign_flag)
  );

  function automatic logic [15:0] model_mul(input logic [15:0] a, input logic [15:0] b,
                                            input logic um, input logic rnd);
    logic [31:0] p;
    logic signed [31:0] sp;
    if (um) p = {16'h0, a} * {16'h0, b};
    else begin
      sp = $signed(a) * $signed(b);
      p  = sp;
    end
    if (rnd) p = p + 32'h0000_8000;
    return p[31:16];
  endfunction

  function automatic string tag_of(input logic v, input logic [4:0] op, input logic um);
    if (!v) return "R10";
    case (op)
      5'b11000: return "R2";
      5'b11001: return "R3";
      5'b11011: return um ? "R5" : "R4";
      5'b11010: return "R6";
      5'b10001: return "R8";
      default:  return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "mr", mr_q, e_mr);
    chk(tag, "ph", ph_q, e_ph);
    chk(tag, "um", {15'h0, um_q}, {15'h0, e_um});
    chk((tag == "R4" || tag == "R5" || tag == "R6") ? "R7" : tag, "zero", {15'h0, zero_flag}, {15'h0, e_z});
    chk((tag == "R4" || tag == "R5" || tag == "R6") ? "R7" : tag, "sign", {15'h0, sign_flag}, {15'h0, e_s});
    chk("R11", "ready", {15'h0, in_ready}, 16'h1);
  endtask

  task automatic step(input logic v, input logic [4:0] op, input logic [15:0] d, input string tag);
    in_valid = v; in_opcode = op; in_operand = d;
    @(posedge clk);
    #1;
    if (v) begin
      case (op)
        5'b11000, 5'b11001: begin
          e_mr = d; e_um = op[0]; e_z = (d == 0); e_s = d[15];
        end
        5'b11011: e_ph = model_mul(e_mr, d, e_um, 1'b0);
        5'b11010: e_ph = model_mul(e_mr, d, e_um, 1'b1);
        5'b10001: begin e_ph = d; e_z = (d == 0); e_s = d[15]; end
        default: ;
      endcase
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] ops [8];
    void'($urandom(32'd20240607));
    ops = '{5'b11000, 5'b11001, 5'b11011, 5'b11010, 5'b10001, 5'b00000, 5'b11100, 5'b10000};
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2, R9: signed load of zero
    step(1, 5'b11000, 16'h0000, "R2");
    // R8, R9: negative PH load
    step(1, 5'b10001, 16'h8001, "R8");
    // R4: -32768 * -32768
    step(1, 5'b11000, 16'h8000, "R2");
    step(1, 5'b11011, 16'h8000, "R4");
    // R6: wrap, 1 * -1 rounded -> 0
    step(1, 5'b11000, 16'h0001, "R2");
    step(1, 5'b11010, 16'hFFFF, "R6");
    step(1, 5'b11011, 16'hFFFF, "R4");
    // R6: -1 * 0x7FFF rounded
    step(1, 5'b11000, 16'hFFFF, "R2");
    step(1, 5'b11010, 16'h7FFF, "R6");
    // R3, R5: unsigned 0xFFFF squared, plain and rounded
    step(1, 5'b11001, 16'hFFFF, "R3");
    step(1, 5'b11011, 16'hFFFF, "R5");
    step(1, 5'b11010, 16'hFFFF, "R6");
    // R10: idle and undefined codes with live operands
    step(0, 5'b11000, 16'h1234, "R10");
    step(1, 5'b10000, 16'h0000, "R10");
    step(1, 5'b01011, 16'h5555, "R10");
    // R7: multiply after flag-changing load leaves flags
    step(1, 5'b10001, 16'h0000, "R9");
    step(1, 5'b11011, 16'h0003, "R7");

    for (int i = 0; i < 400; i++) begin
      logic       v;
      logic [4:0] op;
      logic [15:0] d;
      v  = ($urandom % 8) != 0;
      op = ops[$urandom % 8];
      d  = 16'($urandom);
      if (($urandom % 6) == 0) d = 16'hFFFF;
      step(v, op, d, tag_of(v, op, e_um));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule